// File: doc/BRIEF.md
# Fabric Configuration Sequencer

This block sits between a processor bus and the configuration pins of an attached programmable-logic fabric. Software sets it up through a small 32-bit register window: a control word that takes over the fabric's configuration lines, a status word that reports which phase the fabric is in, a clock-burst counter, and a monitor view of the fabric's status pins. A separate write-only port accepts 32-bit configuration words and shifts them onto a 16-bit data bus, with configuration clock pulses generated by the block.

A phase tracker in hardware follows the fabric from off, through reset and configuration, into initialisation and user operation. The pin-pull bit and the enable bits drive its first steps. Once the fabric reports configuration done, the clock pulses that the burst counter produces move it on to initialisation. The fabric's init-done pin then moves it to user operation. Software polls the phase field, writes the bitstream, and then issues two bursts: a short one to reach initialisation and a long one to finish.

Top module: `fabric_cfg_ctrl`

## Requirements
- R1: After reset the phase field reads 0, `nconfig_o` is high, `dclk_o` is low and the burst-done flag (bit 0 at offset 0xC) is 0. The status word at offset 0x0 carries the phase in bits [2:0] and the live `msel_i` value in bits [7:3]. Phase codes: 0 off, 1 reset, 2 configuration, 3 init, 4 user, 5 unknown; no other code appears.
- R2: The control word at offset 0x4 keeps only bits 0 (drive enable), 1 (active-low chip enable), 2 (pull nCONFIG), 7:6 (ratio code r), 8 (data-port enable) and 9 (wide mode). All other bits read back as 0.
- R3: While bit 0 of the control word is clear or bit 1 is set, the phase reads 0, `nconfig_o` stays high and `dclk_o` stays low.
- R4: With drive active and the pull bit set, `nconfig_o` is low and the phase becomes 1. Clearing the pull bit then moves the phase to 2.
- R5: Turning drive on with the pull bit clear while the phase is 0 gives phase 5.
- R6: Writing N to offset 0x8 produces exactly N pulses on `dclk_o`. Each pulse is one cycle high and is followed by at least one low cycle. After the last pulse the done flag reads 1, and writing 1 to offset 0xC clears it.
- R7: Writing 0 to offset 0x8 sets the done flag on the next cycle. Writing a new count while a burst runs stops the old burst and emits exactly the new count.
- R8: Offset 0x850 bits [3:0] show `nstatus_i`, `conf_done_i`, `init_done_i` and `crc_err_i`, in that order. Offset 0x84C bits [3:0] latch a change on each of those pins. Writing a 1 to a bit at 0x84C clears that bit.
- R9: A word on the data port is taken only when control bit 8 is set, the phase is 2 and no earlier word is still being shifted. Any other word is dropped and produces no pulse.
- R10: A taken word leaves low part first. In wide mode it goes out as two 16-bit halves on `cfg_data_o`. Otherwise it goes out as four bytes on `cfg_data_o[7:0]` with the upper byte 0. Each part is held for 2^r pulses of `dclk_o` and does not change while `dclk_o` is high.
- R11: In phase 2, once `conf_done_i` and `nstatus_i` are both high and INIT_DCLKS pulses have followed, the phase becomes 3 (or 4 if `init_done_i` is high). In phase 3, `init_done_i` high moves it to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| dat_wr | input | 1 | Configuration word write strobe |
| dat_wdata | input | 32 | Configuration word |
| msel_i | input | 5 | Fabric mode-select pins |
| nstatus_i | input | 1 | Fabric status pin (high = no error) |
| conf_done_i | input | 1 | Fabric configuration-done pin |
| init_done_i | input | 1 | Fabric initialisation-done pin |
| crc_err_i | input | 1 | Fabric CRC error pin |
| nconfig_o | output | 1 | Active-low configuration reset to the fabric |
| dclk_o | output | 1 | Configuration clock to the fabric |
| cfg_data_o | output | 16 | Configuration data to the fabric |

## Verification
The bench uses the default parameters: a 12-bit offset, a 32-bit burst counter and INIT_DCLKS of 4. With the 32-bit counter, the full 0x5000-pulse finishing burst runs in simulation, so the fabric model in the bench can carry the phase all the way to user operation. All four ratio codes and both data widths are drawn at random for the shifted words, which exercises every part-by-pulse layout.

// File: rtl/fabric_cfg_ctrl.sv
`timescale 1ns/1ps
module fabric_cfg_ctrl #(
  parameter int ADDR_W     = 12,
  parameter int CNT_W      = 32,
  parameter int INIT_DCLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dat_wr,
  input  logic [31:0]       dat_wdata,
  input  logic [4:0]        msel_i,
  input  logic              nstatus_i,
  input  logic              conf_done_i,
  input  logic              init_done_i,
  input  logic              crc_err_i,
  output logic              nconfig_o,
  output logic              dclk_o,
  output logic [15:0]       cfg_data_o
);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_BCNT  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_BDONE = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_MEVT  = ADDR_W'(12'h84C);
  localparam logic [ADDR_W-1:0] A_MPIN  = ADDR_W'(12'h850);
  localparam logic [9:0]        CTRL_KEEP = 10'h3C7;
  localparam int                PC_W = $clog2(INIT_DCLKS + 2);

  localparam logic [2:0] PH_OFF = 3'd0, PH_RST = 3'd1, PH_CFG = 3'd2,
                         PH_INI = 3'd3, PH_USR = 3'd4, PH_UNK = 3'd5;

  logic [9:0]       ctrl_q;
  logic [2:0]       ph_q;
  logic [PC_W-1:0]  post_q;
  logic [CNT_W-1:0] burst_q;
  logic             done_q, dclk_q;
  logic [31:0]      sh_q;
  logic [2:0]       units_q;
  logic [3:0]       rep_q;
  logic [3:0]       mon_prev_q, mon_evt_q;
  logic             mon_arm_q;

  wire       en    = ctrl_q[0];
  wire       nce   = ctrl_q[1];
  wire       pull  = ctrl_q[2];
  wire [1:0] ratio = ctrl_q[7:6];
  wire       dpath = ctrl_q[8];
  wire       wide  = ctrl_q[9];
  wire       drive = en & ~nce;
  wire [3:0] rep_n = 4'd1 << ratio;

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire wr_bcnt  = reg_wr && reg_addr == A_BCNT;
  wire wr_bdone = reg_wr && reg_addr == A_BDONE;
  wire wr_mevt  = reg_wr && reg_addr == A_MEVT;

  wire burst_on = burst_q != '0;
  wire sh_on    = units_q != 3'd0;
  wire accept   = dat_wr && dpath && ph_q == PH_CFG && !sh_on;
  wire [3:0] mon = {crc_err_i, init_done_i, conf_done_i, nstatus_i};

  assign nconfig_o  = ~(drive & pull);
  assign dclk_o     = drive & dclk_q;
  assign cfg_data_o = wide ? sh_q[15:0] : {8'h00, sh_q[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wdata[9:0] & CTRL_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= '0;
      done_q  <= 1'b0;
      dclk_q  <= 1'b0;
      sh_q    <= '0;
      units_q <= '0;
      rep_q   <= '0;
    end else begin
      if (wr_bdone && reg_wdata[0]) done_q <= 1'b0;
      if (wr_bcnt) begin
        burst_q <= reg_wdata[CNT_W-1:0];
        dclk_q  <= 1'b0;
        if (reg_wdata[CNT_W-1:0] == '0) done_q <= 1'b1;
      end else if (burst_on) begin
        dclk_q <= ~dclk_q;
        if (dclk_q) begin
          burst_q <= burst_q - 1'b1;
          if (burst_q == CNT_W'(1)) done_q <= 1'b1;
        end
      end else if (sh_on) begin
        dclk_q <= ~dclk_q;
        if (dclk_q) begin
          if (rep_q == 4'd1) begin
            rep_q   <= rep_n;
            units_q <= units_q - 3'd1;
            sh_q    <= wide ? {16'h0, sh_q[31:16]} : {8'h0, sh_q[31:8]};
          end else begin
            rep_q <= rep_q - 4'd1;
          end
        end
      end
      if (accept) begin
        sh_q    <= dat_wdata;
        units_q <= wide ? 3'd2 : 3'd4;
        rep_q   <= rep_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_OFF;
      post_q <= '0;
    end else if (!drive) begin
      ph_q   <= PH_OFF;
      post_q <= '0;
    end else if (pull) begin
      ph_q   <= PH_RST;
      post_q <= '0;
    end else begin
      case (ph_q)
        PH_OFF: ph_q <= PH_UNK;
        PH_RST: begin
          ph_q   <= PH_CFG;
          post_q <= '0;
        end
        PH_CFG: begin
          if (conf_done_i && nstatus_i) begin
            if (post_q >= PC_W'(INIT_DCLKS)) ph_q <= init_done_i ? PH_USR : PH_INI;
            else if (dclk_q) post_q <= post_q + 1'b1;
          end else begin
            post_q <= '0;
          end
        end
        PH_INI: if (init_done_i) ph_q <= PH_USR;
        default: ph_q <= ph_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_prev_q <= '0;
      mon_evt_q  <= '0;
      mon_arm_q  <= 1'b0;
    end else begin
      mon_prev_q <= mon;
      mon_arm_q  <= 1'b1;
      mon_evt_q  <= (mon_evt_q & ~(wr_mevt ? reg_wdata[3:0] : 4'h0))
                  | (mon_arm_q ? (mon ^ mon_prev_q) : 4'h0);
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = {24'h0, msel_i, ph_q};
      A_CTRL:  reg_rdata = {22'h0, ctrl_q};
      A_BCNT:  reg_rdata = 32'(burst_q);
      A_BDONE: reg_rdata = {31'h0, done_q};
      A_MEVT:  reg_rdata = {28'h0, mon_evt_q};
      A_MPIN:  reg_rdata = {28'h0, mon};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fabric_cfg_ctrl_chk.sv
`timescale 1ns/1ps
module fabric_cfg_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drive,
  input logic              pull,
  input logic              wide,
  input logic [2:0]        ph,
  input logic              nconfig,
  input logic              dclk,
  input logic [15:0]       data,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              done,
  input logic [CNT_W-1:0]  burst
);
  p_phase_legal_r1: assert property (@(posedge clk) disable iff (!rst_n) ph <= 3'd5);

  p_off_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |=> ph == 3'd0);

  p_pull_enters_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !nconfig |=> ph == 3'd1);

  p_release_to_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drive && !pull && ph == 3'd1 |=> ph == 3'd2);

  p_dclk_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |=> !dclk);

  p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == ADDR_W'(12'h00C) && reg_wdata[0] && burst == '0 |=> !done);

  p_zero_count_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == ADDR_W'(12'h008) && reg_wdata[CNT_W-1:0] == '0 |=> done);

  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dclk && $stable(wide) |-> $stable(data));
endmodule

bind fabric_cfg_ctrl fabric_cfg_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .drive(drive), .pull(pull), .wide(wide), .ph(ph_q),
  .nconfig(nconfig_o), .dclk(dclk_o), .data(cfg_data_o), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .done(done_q), .burst(burst_q)
);

// File: tb/fabric_cfg_ctrl_bench.sv
`timescale 1ns/1ps
module fabric_cfg_ctrl_bench;
  localparam int TGT_INIT = 4 + 32'h5000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dat_wr = 1'b0;
  logic [31:0] dat_wdata = '0;
  logic [4:0]  msel_i = '0;
  logic        nstatus_i = 1'b0, conf_done_i = 1'b0, crc_err_i = 1'b0, init_force = 1'b0;
  logic        init_done_i;
  logic        nconfig_o, dclk_o;
  logic [15:0] cfg_data_o;

  int n_chk = 0, n_bad = 0, npulse = 0, cd_pulses = 0;
  logic [15:0] cap [0:63];

  assign init_done_i = init_force | (cd_pulses >= TGT_INIT);

  fabric_cfg_ctrl u_fabric_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dat_wr(dat_wr),
    .dat_wdata(dat_wdata), .msel_i(msel_i), .nstatus_i(nstatus_i),
    .conf_done_i(conf_done_i), .init_done_i(init_done_i), .crc_err_i(crc_err_i),
    .nconfig_o(nconfig_o), .dclk_o(dclk_o), .cfg_data_o(cfg_data_o)
  );

  always @(negedge clk) begin
    if (dclk_o) begin
      cap[npulse & 63] = cfg_data_o;
      npulse = npulse + 1;
      if (conf_done_i) cd_pulses = cd_pulses + 1;
    end
    if (!conf_done_i) cd_pulses = 0;
  end

  function automatic logic [15:0] exp_part(logic [31:0] w, logic wd, int idx);
    return wd ? 16'(w >> (16 * idx)) : {8'h00, 8'(w >> (8 * idx))};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dat(logic [31:0] w);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = w;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic wait_done(int lim);
    logic [31:0] d;
    for (int i = 0; i < lim; i++) begin
      rd(12'h00C, d);
      if (d[0]) break;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5ns * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    int base;
    seed = $urandom(32'h5eed_0011);
    cyc(3); rst_n = 1'b1; cyc(2);

    rd(12'h000, d); chk("R1 reset phase", d[2:0], 0);
    chk("R1 reset nconfig", nconfig_o, 1);
    chk("R1 reset dclk", dclk_o, 0);
    rd(12'h00C, d); chk("R1 reset done", d, 0);
    msel_i = 5'($urandom);
    rd(12'h000, d); chk("R1 msel field", d[7:3], msel_i);

    wr(12'h004, 32'hFFFF_FFFF); cyc(2);
    rd(12'h004, d); chk("R2 ctrl readback", d, 32'h3C7);
    rd(12'h000, d); chk("R3 chip enable high phase", d[2:0], 0);
    chk("R3 chip enable high nconfig", nconfig_o, 1);
    wr(12'h004, 32'h0000_0004); wr(12'h008, 5); base = npulse; cyc(14);
    chk("R3 no dclk when disabled", npulse - base, 0);
    chk("R3 disabled nconfig", nconfig_o, 1);
    wr(12'h00C, 1);

    wr(12'h004, 32'h1); cyc(2);
    rd(12'h000, d); chk("R5 unknown phase", d[2:0], 5);
    wr(12'h004, 32'h5); cyc(2);
    chk("R4 nconfig low", nconfig_o, 0);
    rd(12'h000, d); chk("R4 reset phase", d[2:0], 1);
    wr(12'h004, 32'h1); cyc(2);
    rd(12'h000, d); chk("R4 config phase", d[2:0], 2);

    base = npulse; dat(32'hA5A5_1234); cyc(12);
    chk("R9 word dropped without data enable", npulse - base, 0);

    for (int k = 0; k < 3; k++) begin
      int n = 1 + int'($urandom % 20);
      base = npulse; wr(12'h008, n); wait_done(200); cyc(2);
      chk("R6 burst pulse count", npulse - base, n);
      rd(12'h00C, d); chk("R6 done set", d[0], 1);
      wr(12'h00C, 1); rd(12'h00C, d); chk("R6 done cleared", d[0], 0);
    end

    @(negedge clk); reg_wr = 1'b1; reg_addr = 12'h008; reg_wdata = 0;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 12'h00C; #1;
    chk("R7 zero count done next cycle", reg_rdata[0], 1);
    wr(12'h00C, 1);
    base = npulse; wr(12'h008, 10); cyc(5);
    wr(12'h008, 3);
    base = base + (npulse - base);
    wait_done(100); cyc(2);
    chk("R7 restart emits new count", npulse - base, 3);
    wr(12'h00C, 1);

    for (int k = 0; k < 8; k++) begin
      logic [1:0] r = 2'($urandom);
      logic wd = 1'($urandom);
      logic [31:0] w = $urandom;
      int parts = wd ? 2 : 4;
      int reps = 1 << r;
      if (k == 0) begin r = 2'd3; wd = 1'b0; parts = 4; reps = 8; end
      wr(12'h004, 32'h101 | (32'(r) << 6) | (32'(wd) << 9));
      base = npulse; dat(w);
      for (int i = 0; i < 300 && npulse - base < parts * reps; i++) cyc(1);
      cyc(4);
      chk("R10 pulses per word", npulse - base, parts * reps);
      for (int i = 0; i < parts * reps; i++)
        chk(wd ? "R10 wide part" : "R10 byte part", cap[(base + i) & 63], exp_part(w, wd, i / reps));
    end
    wr(12'h004, 32'h301);
    base = npulse; dat(32'h1111_2222); dat(32'h3333_4444);
    cyc(20);
    chk("R9 word dropped while shifting", npulse - base, 2);
    chk("R9 first word kept", cap[base & 63], 16'h2222);

    wr(12'h84C, 32'hF);
    nstatus_i = 1'b1; init_force = 1'b1; crc_err_i = 1'b1; cyc(3);
    rd(12'h850, d); chk("R8 pin view", d, 32'hD);
    rd(12'h84C, d); chk("R8 change latch", d, 32'hD);
    wr(12'h84C, 32'h1); rd(12'h84C, d); chk("R8 partial clear", d, 32'hC);
    init_force = 1'b0; crc_err_i = 1'b0; cyc(3);
    wr(12'h84C, 32'hF); rd(12'h84C, d); chk("R8 full clear", d, 0);

    conf_done_i = 1'b1; cyc(2);
    rd(12'h000, d); chk("R11 stays config before clocks", d[2:0], 2);
    wr(12'h008, 4); wait_done(50); cyc(3);
    rd(12'h000, d); chk("R11 init phase after short burst", d[2:0], 3);
    wr(12'h00C, 1);
    wr(12'h008, 32'h5000); wait_done(45000); cyc(3);
    rd(12'h000, d); chk("R11 user phase after long burst", d[2:0], 4);
    base = npulse; dat(32'hDEAD_BEEF); cyc(12);
    chk("R9 word dropped in user phase", npulse - base, 0);

    wr(12'h004, 32'h0); cyc(2);
    rd(12'h000, d); chk("R3 phase off after disable", d[2:0], 0);
    summary();
  end
endmodule